// File: doc/BRIEF.md
# Widening Signed Vector Add/Subtract Unit

This unit performs lane-wise signed addition or subtraction on packed vectors and widens each result lane to twice the width of its source lanes. It receives an instruction word and two 128-bit source vectors. A half-select bit in the word picks the low or high 64 bits of both sources. Each narrow lane in that half is sign-extended to double width before the add or subtract. The double-width lanes together fill a 128-bit result.

A small decoder inside the unit checks the instruction word's fixed bit pattern. It brings out the lane-size code, the half select, the operation and the three register indices as plain signals, so that the surrounding pipeline can address its register file. One registered stage holds the result. A valid strobe goes with the input and another with the output. The unit does not produce or touch any condition flags.

Top module: `simd_widen_addsub`

## Requirements
- R1: The size field `instr[23:22]` sets the source lane width: code 0 gives eight 8-bit lanes, code 1 gives four 16-bit lanes, and code 2 gives two 32-bit lanes. Result lane i has width 2W for a source width W and sits at `result[i*2W +: 2W]`.
- R2: When `instr[30]` is 0, the operands come from `src_a[63:0]` and `src_b[63:0]`. When it is 1, they come from bits [127:64] of each source.
- R3: Both source lanes are sign-extended to 2W bits before the arithmetic.
- R4: When `instr[13]` is 1, each result lane is the `src_a` lane minus the `src_b` lane. When it is 0, each result lane is their sum.
- R5: Each lane result is kept at exactly 2W bits, so the extreme cases are exact: most negative minus most positive, most positive minus most negative, and the sum of two most negative values.
- R6: `dec_hit` is high only when all of these hold: bits 31 and 29 are 0, bits [28:24] are 01110, bit 21 is 1, bits 15, 14 and 12 are 0, bits [11:10] are 00, and the size code is not 3. The decoder always drives `dec_rd`=`instr[4:0]`, `dec_rn`=`instr[9:5]`, `dec_rm`=`instr[20:16]`, `dec_size`=`instr[23:22]`, `dec_half`=`instr[30]` and `dec_sub`=`instr[13]`.
- R7: When the fixed pattern matches and the size code is 3, `dec_undef` is high. If such a word is accepted, the next cycle shows `result` as all zeros and `out_valid` low.
- R8: A word that does not match the fixed pattern raises neither `dec_hit` nor `dec_undef`. If it is accepted, the next cycle shows `result` as zero and `out_valid` low.
- R9: A word that decodes (`dec_hit` high) and is presented with `in_valid` high produces its result and `out_valid` high exactly one clock later.
- R10: While `in_valid` is low, `result` holds its value and `out_valid` goes low on the next clock.
- R11: Driving `rst_n` low clears `result` and `out_valid` at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and sources are present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | First source vector (minuend) |
| src_b | input | 128 | Second source vector (subtrahend or addend) |
| dec_hit | output | 1 | Word is a supported widening add/subtract |
| dec_undef | output | 1 | Pattern matches but size code is reserved |
| dec_size | output | 2 | Lane size code |
| dec_half | output | 1 | Upper-half select |
| dec_sub | output | 1 | 1 for subtract, 0 for add |
| dec_rd | output | 5 | Destination register index |
| dec_rn | output | 5 | First source register index |
| dec_rm | output | 5 | Second source register index |
| result | output | 128 | Registered widened result |
| out_valid | output | 1 | `result` holds a fresh valid result |

## Verification
The only state in the unit is the result register and its valid flag. A fault in either is visible at the ports one clock after the operation that wrote it. A wrong enable shows up as a result that changes while `in_valid` is low. A lane that is misplaced or sign-extended wrongly corrupts a specific bit range of `result` in that same following cycle. Operands with the sign bit set in every lane, across all sizes and both halves, make that corruption show up in the upper half of each result lane.

// File: rtl/simd_wide_pkg.sv
package simd_wide_pkg;
  localparam int VEC_W   = 128;
  localparam int HALF_W  = VEC_W / 2;
  localparam int BASE_EW = 8;
  localparam int NSIZES  = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } lane_size_e;

  localparam logic [4:0] GRP_CODE = 5'b01110;
endpackage

// File: rtl/swa_decode.sv
module swa_decode
  import simd_wide_pkg::*;
(
  input  logic [31:0] instr,
  output logic        hit,
  output logic        undef,
  output logic [1:0]  size,
  output logic        half,
  output logic        sub,
  output logic [4:0]  rd,
  output logic [4:0]  rn,
  output logic [4:0]  rm
);
  logic       fixed_ok;
  lane_size_e sz;

  always_comb begin
    sz       = lane_size_e'(instr[23:22]);
    fixed_ok = (instr[31] == 1'b0) && (instr[29] == 1'b0) &&
               (instr[28:24] == GRP_CODE) && instr[21] &&
               (instr[15:14] == 2'b00) && (instr[12] == 1'b0) &&
               (instr[11:10] == 2'b00);
    hit   = fixed_ok && (sz != SZ_RSVD);
    undef = fixed_ok && (sz == SZ_RSVD);
    size  = instr[23:22];
    half  = instr[30];
    sub   = instr[13];
    rd    = instr[4:0];
    rn    = instr[9:5];
    rm    = instr[20:16];
  end
endmodule

// File: rtl/swa_lane.sv
module swa_lane #(
  parameter int EW = 8
) (
  input  logic [EW-1:0]   a_i,
  input  logic [EW-1:0]   b_i,
  input  logic            sub_i,
  output logic [2*EW-1:0] y_o
);
  localparam int WW = 2 * EW;
  logic [WW-1:0] ax, bx;

  always_comb begin
    ax  = {{EW{a_i[EW-1]}}, a_i};
    bx  = {{EW{b_i[EW-1]}}, b_i};
    y_o = sub_i ? (ax - bx) : (ax + bx);
  end
endmodule

// File: rtl/swa_widen.sv
module swa_widen
  import simd_wide_pkg::*;
(
  input  logic [HALF_W-1:0] a_half,
  input  logic [HALF_W-1:0] b_half,
  input  logic [1:0]        size,
  input  logic              sub,
  output logic [VEC_W-1:0]  y
);
  for (genvar k = 0; k < NSIZES; k++) begin : g_size
    localparam int EW = BASE_EW << k;
    localparam int NL = HALF_W / EW;
    logic [VEC_W-1:0] res_k;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      swa_lane #(.EW(EW)) u_lane (
        .a_i  (a_half[i*EW +: EW]),
        .b_i  (b_half[i*EW +: EW]),
        .sub_i(sub),
        .y_o  (res_k[i*2*EW +: 2*EW])
      );
    end
  end

  always_comb begin
    unique case (lane_size_e'(size))
      SZ_BYTE: y = g_size[0].res_k;
      SZ_HALF: y = g_size[1].res_k;
      SZ_WORD: y = g_size[2].res_k;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_widen_addsub.sv
module simd_widen_addsub
  import simd_wide_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        instr,
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  output logic               dec_hit,
  output logic               dec_undef,
  output logic [1:0]         dec_size,
  output logic               dec_half,
  output logic               dec_sub,
  output logic [4:0]         dec_rd,
  output logic [4:0]         dec_rn,
  output logic [4:0]         dec_rm,
  output logic [VEC_W-1:0]   result,
  output logic               out_valid
);
  logic [HALF_W-1:0] a_half, b_half;
  logic [VEC_W-1:0]  widened;
  logic [VEC_W-1:0]  result_d;
  logic              result_en;
  logic              valid_d;

  swa_decode u_dec (
    .instr(instr),
    .hit  (dec_hit),
    .undef(dec_undef),
    .size (dec_size),
    .half (dec_half),
    .sub  (dec_sub),
    .rd   (dec_rd),
    .rn   (dec_rn),
    .rm   (dec_rm)
  );

  always_comb begin
    a_half = dec_half ? src_a[VEC_W-1:HALF_W] : src_a[HALF_W-1:0];
    b_half = dec_half ? src_b[VEC_W-1:HALF_W] : src_b[HALF_W-1:0];
  end

  swa_widen u_wid (
    .a_half(a_half),
    .b_half(b_half),
    .size  (dec_size),
    .sub   (dec_sub),
    .y     (widened)
  );

  // next-state
  always_comb begin
    result_en = in_valid;
    result_d  = dec_hit ? widened : '0;
    valid_d   = in_valid && dec_hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
      if (result_en) result <= result_d;
    end
  end
endmodule

// File: rtl/swa_chk.sv
module swa_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         dec_hit,
  input logic         dec_undef,
  input logic         dec_sub,
  input logic         dec_half,
  input logic [1:0]   dec_size,
  input logic [7:0]   a_lo8,
  input logic [7:0]   b_lo8,
  input logic [127:0] result,
  input logic         out_valid
);
  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_hit) |=> out_valid);

  // R10
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R7
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_undef) |=> (result == '0 && !out_valid));

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_hit) |=> (result == '0 && !out_valid));

  // R6
  hit_undef_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_hit && dec_undef));

  // R3
  lane0_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_hit && dec_size == 2'd0 && !dec_half && dec_sub) |=>
    result[15:0] == $past({{8{a_lo8[7]}}, a_lo8} - {{8{b_lo8[7]}}, b_lo8}));
endmodule

bind simd_widen_addsub swa_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .dec_hit  (dec_hit),
  .dec_undef(dec_undef),
  .dec_sub  (dec_sub),
  .dec_half (dec_half),
  .dec_size (dec_size),
  .a_lo8    (src_a[7:0]),
  .b_lo8    (src_b[7:0]),
  .result   (result),
  .out_valid(out_valid)
);

// File: tb/sim_simd_widen_addsub.sv
module sim_simd_widen_addsub;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [127:0] src_a, src_b;
  logic         dec_hit, dec_undef, dec_half, dec_sub;
  logic [1:0]   dec_size;
  logic [4:0]   dec_rd, dec_rn, dec_rm;
  logic [127:0] result;
  logic         out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_widen_addsub u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .dec_hit(dec_hit), .dec_undef(dec_undef),
    .dec_size(dec_size), .dec_half(dec_half), .dec_sub(dec_sub),
    .dec_rd(dec_rd), .dec_rn(dec_rn), .dec_rm(dec_rm),
    .result(result), .out_valid(out_valid)
  );

  function automatic logic [31:0] mk(input logic half, input logic [1:0] sz,
                                     input logic sub, input logic [4:0] rd,
                                     input logic [4:0] rn, input logic [4:0] rm);
    return {1'b0, half, 1'b0, 5'b01110, sz, 1'b1, rm, 2'b00, sub, 1'b0,
            2'b00, rn, rd};
  endfunction

  function automatic logic [127:0] ref_calc(input logic [127:0] a, input logic [127:0] b,
                                            input int sz, input logic half, input logic sub);
    logic [127:0] r = '0;
    int ew = 8 << sz;
    logic [63:0] ha = half ? a[127:64] : a[63:0];
    logic [63:0] hb = half ? b[127:64] : b[63:0];
    for (int i = 0; i < 64 / ew; i++) begin
      logic [63:0] ta = ha >> (i * ew);
      logic [63:0] tb = hb >> (i * ew);
      longint xa = longint'(ta << (64 - ew)) >>> (64 - ew);
      longint xb = longint'(tb << (64 - ew)) >>> (64 - ew);
      longint s  = sub ? (xa - xb) : (xa + xb);
      for (int j = 0; j < 2 * ew; j++) r[i * 2 * ew + j] = s[j];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // drive one accepted word, check one clock later
  task automatic issue(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    instr = w; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0;
    #1;
    chk("R11 result in reset", result, '0);
    chk("R11 out_valid in reset", {127'd0, out_valid}, '0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_decode();
    logic [31:0] w;
    w = mk(1'b1, 2'd1, 1'b1, 5'd3, 5'd17, 5'd30);
    @(negedge clk); instr = w; #1;
    chk("R6 hit", {127'd0, dec_hit}, 128'd1);
    chk("R6 fields", {108'd0, dec_rd, dec_rn, dec_rm, dec_size, dec_half, dec_sub},
        {108'd0, 5'd3, 5'd17, 5'd30, 2'd1, 1'b1, 1'b1});
    chk("R6 subtract base word", {96'd0, mk(1'b0, 2'd0, 1'b1, 5'd0, 5'd0, 5'd0)},
        {96'd0, 32'h0E20_2000});
    instr = w | 32'h0000_1000; #1;
    chk("R8 bit12 set no hit", {126'd0, dec_hit, dec_undef}, '0);
  endtask

  task automatic t_op(input int sz, input logic half, input logic sub,
                      input logic [127:0] a, input logic [127:0] b, input string req);
    issue(mk(half, sz[1:0], sub, 5'd1, 5'd2, 5'd3), a, b);
    chk(req, result, ref_calc(a, b, sz, half, sub));
    chk("R9 out_valid", {127'd0, out_valid}, 128'd1);
  endtask

  task automatic t_sweep();
    logic [127:0] a = 128'h8F7E_6D5C_4B3A_2918_F7E6_D5C4_B3A2_9180;
    logic [127:0] b = 128'h1357_9BDF_ECA8_6420_7F80_01FF_8000_7FFF;
    for (int sz = 0; sz < 3; sz++)
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < 2; s++)
          t_op(sz, h[0], s[0], a, b, "R1 R2 R3 R4 sweep");
  endtask

  task automatic t_extremes();
    // R5: lanes of min vs max per size
    t_op(0, 1'b0, 1'b1, {64'd0, {8{8'h80}}}, {64'd0, {8{8'h7F}}}, "R5 min-max 8");
    chk("R5 -255 lane", {112'd0, result[15:0]}, {112'd0, 16'hFF01});
    t_op(0, 1'b0, 1'b1, {64'd0, {8{8'h7F}}}, {64'd0, {8{8'h80}}}, "R5 max-min 8");
    chk("R5 +255 lane", {112'd0, result[15:0]}, {112'd0, 16'h00FF});
    t_op(2, 1'b1, 1'b1, {{2{32'h8000_0000}}, 64'd0}, {{2{32'h7FFF_FFFF}}, 64'd0}, "R5 min-max 32");
    t_op(1, 1'b1, 1'b0, {{4{16'h8000}}, 64'd0}, {{4{16'h8000}}, 64'd0}, "R5 min+min 16");
    chk("R5 -65536 lane", {96'd0, result[31:0]}, {96'd0, 32'hFFFF_0000});
  endtask

  task automatic t_undef();
    logic [31:0] w = mk(1'b0, 2'd3, 1'b1, 5'd1, 5'd2, 5'd3);
    t_op(1, 1'b0, 1'b0, {128{1'b1}}, {128{1'b1}}, "R1 preload");
    @(negedge clk); instr = w; #1;
    chk("R7 undef flag", {126'd0, dec_hit, dec_undef}, 128'd1);
    issue(w, {128{1'b1}}, {128{1'b1}});
    chk("R7 result zero", result, '0);
    chk("R7 out_valid low", {127'd0, out_valid}, '0);
  endtask

  task automatic t_nomatch();
    t_op(0, 1'b0, 1'b0, {128{1'b1}}, 128'd5, "R1 preload");
    issue(32'hFFFF_FFFF, {128{1'b1}}, 128'd5);
    chk("R8 result zero", result, '0);
    chk("R8 out_valid low", {127'd0, out_valid}, '0);
  endtask

  task automatic t_hold();
    logic [127:0] keep;
    t_op(2, 1'b0, 1'b0, 128'h1234, 128'h5678, "R1 preload");
    keep = result;
    src_a = 128'hDEAD; src_b = 128'hBEEF;
    @(negedge clk); @(negedge clk);
    chk("R10 result held", result, keep);
    chk("R10 out_valid low", {127'd0, out_valid}, '0);
    issue(mk(1'b0, 2'd0, 1'b0, 5'd0, 5'd0, 5'd0), 128'h7, 128'h9);
    rst_n = 1'b0; #1;
    chk("R11 async clear", {result[126:0], out_valid}, '0);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_decode();
    t_sweep();
    t_extremes();
    t_undef();
    t_nomatch();
    t_hold();
    finish_run();
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule